// File: doc/BRIEF.md
# Configurable GPIO Interrupt Register Core

This block holds the programming state of eight general-purpose pins and turns it into per-pin drive controls. Each pin is an input or an output. An output pin drives either as push-pull or as open-drain, emulated through a separate output-enable vector. The pads themselves are outside the block. Input pins are resynchronised, and every change of level is caught in a sticky status bit. A per-pin mask and a global enable decide which of these changes pull the active-low alert line.

A host reaches the registers through a simple single-cycle read/write port. Read data is combinational from the selected address. In fan mode an external controller drives the upper four pins through the `fanLevel` input. Those pins then act as open-drain outputs and no longer raise status or alerts. The fan speed register is storage only; the pattern generation sits outside this block.

Top module: `gpio_irq_core`

## Requirements
- R1: After reset: configuration (address 0), direction (1), drive type (2), status (3), mask (4) and fan speed (6) read 00h, data (5) reads FFh, `alertN` is 1 and `pinOe` is 00h.
- R2: Address 0 keeps bits 1:0, where bit 0 is the global interrupt enable and bit 1 is fan mode. Address 6 keeps bits 2:0. The other bits of both registers read 0. Address 7 reads 00h. Writes to address 3 have no effect.
- R3: For a pin with direction bit 1 and drive bit 1 (push-pull): `pinOe`=1 and `pinOut`=data bit. With direction 1 and drive 0 (open-drain): `pinOe`=NOT data bit and `pinOut`=0. With direction 0 (input): `pinOe`=0 and `pinOut`=0.
- R4: A read of address 5 returns the stored data bit for output pins and the synchronised pin level for input pins. A pin level becomes visible after the second rising edge that follows its change.
- R5: A write to address 5 updates only the bits of pins whose direction bit is 1. Bits of input pins keep their value.
- R6: A change of level on an input pin sets its status bit at the third rising edge after the change. Pins configured as outputs set no status.
- R7: A read of address 3 returns the status before clearing. It then clears all status bits at that clock edge.
- R8: A change detected at the same edge as a status read stays set in status.
- R9: `alertN` goes low at the edge where a status bit sets, provided that pin's mask bit is 1 and the global enable is 1. It stays low until it is cleared. With the enable or the mask bit at 0, no alert is raised.
- R10: A pulse on `alertClr` or a status read releases `alertN` at that edge.
- R11: In fan mode, pins 7:4 give `pinOe`=NOT `fanLevel` and `pinOut`=0, regardless of the direction, drive and data registers. They raise no status and no alert. Pins 3:0 are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects only) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from regAddr |
| pinIn | input | 8 | Pin levels, asynchronous |
| pinOut | output | 8 | Pin drive value |
| pinOe | output | 8 | Pin driver enable |
| fanLevel | input | 4 | Fan-mode levels for pins 7:4 |
| alertClr | input | 1 | Alert acknowledge pulse |
| alertN | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a pin change that is detected at exactly the edge where the host reads status. The clear and the set then meet in one register update. The stimulus reaches it by timing a status read three edges after a directed pin transition. The bench then checks that the new bit survives while the older bits are cleared. Random traffic mixes register writes, pin flips, fan-level changes and acknowledges. After each step it compares the reads and drive vectors with a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    ADDR_CFG  = 3'd0,
    ADDR_DIR  = 3'd1,
    ADDR_DRV  = 3'd2,
    ADDR_STAT = 3'd3,
    ADDR_MASK = 3'd4,
    ADDR_DATA = 3'd5,
    ADDR_FAN  = 3'd6
  } regAddr_e;

  typedef struct packed {
    logic wrCfg;
    logic wrDir;
    logic wrDrv;
    logic wrMask;
    logic wrData;
    logic wrFan;
    logic rdStat;
    logic ackAlert;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic       alertClr,
  output strobe_t    stb
);
  always_comb begin
    stb          = '0;
    stb.ackAlert = alertClr;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_CFG:  stb.wrCfg  = 1'b1;
        ADDR_DIR:  stb.wrDir  = 1'b1;
        ADDR_DRV:  stb.wrDrv  = 1'b1;
        ADDR_MASK: stb.wrMask = 1'b1;
        ADDR_DATA: stb.wrData = 1'b1;
        ADDR_FAN:  stb.wrFan  = 1'b1;
        default:   ;
      endcase
    end
    stb.rdStat = regRdEn && (regAddr == ADDR_STAT);
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int FAN_PINS = 4,
  parameter int SPD_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [2:0]       regAddr,
  input  logic [NPINS-1:0] wrData,
  output logic [NPINS-1:0] rdData,
  input  logic [NPINS-1:0] pinIn,
  input  logic [FAN_PINS-1:0] fanLevel,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             alertN
);
  localparam int FAN_LO = NPINS - FAN_PINS;
  localparam logic [NPINS-1:0] FAN_MASK = {{FAN_PINS{1'b1}}, {FAN_LO{1'b0}}};

  logic cfgIe, cfgFan;
  logic [NPINS-1:0] dirQ, drvQ, maskQ, dataQ, statQ;
  logic [SPD_BITS-1:0] fanSpdQ;
  logic [NPINS-1:0] syncA, syncB, prevQ;
  logic [NPINS-1:0] fanSel, eligible, change;
  logic alertQ, alertSet;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgIe   <= 1'b0;
      cfgFan  <= 1'b0;
      dirQ    <= '0;
      drvQ    <= '0;
      maskQ   <= '0;
      dataQ   <= '1;
      fanSpdQ <= '0;
    end else begin
      if (stb.wrCfg) begin
        cfgIe  <= wrData[0];
        cfgFan <= wrData[1];
      end
      if (stb.wrDir)  dirQ    <= wrData;
      if (stb.wrDrv)  drvQ    <= wrData;
      if (stb.wrMask) maskQ   <= wrData;
      if (stb.wrFan)  fanSpdQ <= wrData[SPD_BITS-1:0];
      if (stb.wrData) dataQ   <= (dataQ & ~dirQ) | (wrData & dirQ);
    end
  end

  // input synchroniser and change detection (idle-high pins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '1;
      syncB <= '1;
      prevQ <= '1;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign fanSel   = cfgFan ? FAN_MASK : '0;
  assign eligible = ~dirQ & ~fanSel;
  assign change   = (syncB ^ prevQ) & eligible;
  assign alertSet = cfgIe && ((change & maskQ) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statQ  <= '0;
      alertQ <= 1'b0;
    end else begin
      statQ  <= (stb.rdStat ? '0 : statQ) | change;
      alertQ <= ((stb.rdStat || stb.ackAlert) ? 1'b0 : alertQ) | alertSet;
    end
  end

  assign alertN = ~alertQ;

  // per-pin drive emulation
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i >= FAN_LO) begin : g_fanable
      always_comb begin
        if (cfgFan) begin
          pinOe[i]  = ~fanLevel[i-FAN_LO];
          pinOut[i] = 1'b0;
        end else begin
          pinOe[i]  = dirQ[i] & (drvQ[i] | ~dataQ[i]);
          pinOut[i] = dirQ[i] & drvQ[i] & dataQ[i];
        end
      end
    end else begin : g_plain
      assign pinOe[i]  = dirQ[i] & (drvQ[i] | ~dataQ[i]);
      assign pinOut[i] = dirQ[i] & drvQ[i] & dataQ[i];
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_CFG:  rdData[1:0] = {cfgFan, cfgIe};
      ADDR_DIR:  rdData = dirQ;
      ADDR_DRV:  rdData = drvQ;
      ADDR_STAT: rdData = statQ;
      ADDR_MASK: rdData = maskQ;
      ADDR_DATA: rdData = (dataQ & dirQ) | (syncB & ~dirQ);
      ADDR_FAN:  rdData[SPD_BITS-1:0] = fanSpdQ;
      default:   rdData = '0;
    endcase
  end

  // R5: input-pin bits of data never move
  a_r5_input_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((dataQ ^ $past(dataQ)) & ~$past(dirQ)) == '0);
  // R7: a read with no fresh change leaves status empty
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdStat && change == '0) |=> statQ == '0);
  // R8: a detected change is always present afterwards
  a_r8_change_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (change != '0) |=> ((statQ & $past(change)) == $past(change)));
  // R9: alert only rises with the global enable on
  a_r9_alert_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alertQ) |-> $past(cfgIe));
  // R10: acknowledge without a new event releases the alert
  a_r10_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb.ackAlert || stb.rdStat) && !alertSet) |=> alertN);
  // R11: fan pins gain no new status bits
  a_r11_fan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfgFan |=> ((statQ & ~$past(statQ) & FAN_MASK) == '0));
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [7:0] pinIn,
  output logic [7:0] pinOut,
  output logic [7:0] pinOe,
  input  logic [3:0] fanLevel,
  input  logic       alertClr,
  output logic       alertN
);
  strobe_t stb;

  gpio_irq_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .alertClr(alertClr),
    .stb     (stb)
  );

  gpio_irq_dp #(.NPINS(8), .FAN_PINS(4), .SPD_BITS(3)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .regAddr (regAddr),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .pinIn   (pinIn),
    .fanLevel(fanLevel),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .alertN  (alertN)
  );
endmodule

// File: tb/gpio_irq_core_test.sv
module gpio_irq_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, alertClr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0, pinIn = 8'hFF;
  logic [3:0] fanLevel = 4'hF;
  logic [7:0] regRdData, pinOut, pinOe;
  logic alertN;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [1:0] mCfg = 0;
  logic [7:0] mDir = 0, mDrv = 0, mMask = 0, mData = 8'hFF, mStat = 0, mPin = 8'hFF;
  logic [2:0] mFan = 0;
  logic mAlert = 0;

  gpio_irq_core uut (.*);

  always #4 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return {6'd0, mCfg};
      3'd1: return mDir;
      3'd2: return mDrv;
      3'd3: return mStat;
      3'd4: return mMask;
      3'd5: return (mData & mDir) | (mPin & ~mDir);
      3'd6: return {5'd0, mFan};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] expDrive();
    logic [7:0] oe, out;
    for (int i = 0; i < 8; i++) begin
      if (mCfg[1] && i >= 4) begin oe[i] = ~fanLevel[i-4]; out[i] = 1'b0; end
      else if (!mDir[i]) begin oe[i] = 1'b0; out[i] = 1'b0; end
      else if (mDrv[i]) begin oe[i] = 1'b1; out[i] = mData[i]; end
      else begin oe[i] = ~mData[i]; out[i] = 1'b0; end
    end
    return {oe, out};
  endfunction

  function automatic logic [7:0] eligible();
    return ~mDir & (mCfg[1] ? 8'h0F : 8'hFF);
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0;
    case (a)
      3'd0: mCfg = d[1:0];
      3'd1: mDir = d;
      3'd2: mDrv = d;
      3'd4: mMask = d;
      3'd5: mData = (mData & ~mDir) | (d & mDir);
      3'd6: mFan = d[2:0];
      default: ;
    endcase
  endtask

  task automatic rdCheck(logic [2:0] a, string req);
    regRdEn = 1; regAddr = a;
    #1 check(req, regRdData, expRead(a));
    tick();
    regRdEn = 0;
    if (a == 3'd3) begin mStat = 0; mAlert = 0; end
  endtask

  task automatic setPins(logic [7:0] p);
    logic [7:0] chg;
    chg = (p ^ mPin) & eligible();
    pinIn = p;
    repeat (3) tick();
    mPin = p;
    mStat |= chg;
    if (mCfg[0] && (chg & mMask) != 0) mAlert = 1;
  endtask

  task automatic checkDrive(string req);
    logic [15:0] e;
    e = expDrive();
    check(req, pinOe, e[15:8]);
    check(req, pinOut, e[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    for (int a = 0; a < 7; a++) rdCheck(3'(a), "R1");
    check("R1 alertN", {7'd0, alertN}, 8'h01);
    check("R1 pinOe", pinOe, 8'h00);
    // R2 reserved bits and unused address
    wr(3'd0, 8'hFC); rdCheck(3'd0, "R2");
    wr(3'd6, 8'hFF); rdCheck(3'd6, "R2");
    wr(3'd3, 8'hFF); rdCheck(3'd3, "R2");
    rdCheck(3'd7, "R2");
    wr(3'd0, 8'h00);
    // R3 drive modes
    wr(3'd1, 8'hF0); wr(3'd2, 8'hCC); wr(3'd5, 8'hA5);
    checkDrive("R3");
    // R4 R5 data read/write with mixed direction
    rdCheck(3'd5, "R4 R5");
    // R6 output pin changes ignored, input changes latched
    setPins(8'h0F); rdCheck(3'd3, "R6");
    // R9 alert with enable and mask
    wr(3'd0, 8'h01); wr(3'd4, 8'h03);
    setPins(8'h0E);
    check("R9 alertN", {7'd0, alertN}, {7'd0, ~mAlert});
    // R10 acknowledge
    alertClr = 1; tick(); alertClr = 0; mAlert = 0;
    check("R10 alertN", {7'd0, alertN}, 8'h01);
    rdCheck(3'd3, "R7");
    // R9 masked pin raises no alert
    setPins(8'h0A);
    check("R9 masked", {7'd0, alertN}, 8'h01);
    rdCheck(3'd3, "R7");
    // R8 change detected in the status-read cycle
    pinIn = 8'h0B;
    tick(); tick();
    regRdEn = 1; regAddr = 3'd3;
    #1 check("R8 pre", regRdData, 8'h00);
    tick(); regRdEn = 0;
    mPin = 8'h0B; mStat = 8'h01; mAlert = 1;
    alertClr = 1; tick(); alertClr = 0; mAlert = 0;
    rdCheck(3'd3, "R8");
    // R11 fan mode
    wr(3'd1, 8'h00); wr(3'd4, 8'hFF); wr(3'd0, 8'h03);
    fanLevel = 4'h5; #1 checkDrive("R11");
    setPins(8'hF4);
    rdCheck(3'd3, "R11");
    check("R11 alertN", {7'd0, alertN}, {7'd0, ~mAlert});
    alertClr = 1; tick(); alertClr = 0; mAlert = 0;
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: wr(3'($urandom_range(0, 7)), 8'($urandom));
        2: setPins(8'($urandom));
        3: rdCheck(3'($urandom_range(0, 7)), "R2 R4 R6 R7");
        4: begin fanLevel = 4'($urandom); #1; end
        default: begin alertClr = 1; tick(); alertClr = 0; mAlert = 0; end
      endcase
      checkDrive("R3 R11");
      check("R9 R10 alertN", {7'd0, alertN}, {7'd0, ~mAlert});
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule